// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block turns one 6-bit operand specifier into a resolved operand for a 16-bit processor with eight general registers. Register 7 is the program counter. The block is started with a specifier and a byte/word flag. It reads the selected register and writes back any post-increment, pre-decrement or program-counter advance. It issues word reads on a simple memory port for pointers, index words and the operand itself. When it finishes, it presents the operand value and its effective address together with a one-cycle `done` pulse.

Memory is organised as 16-bit words and ignores address bit 0. Byte operands are taken from the low or high half of the word that was read, as selected by bit 0 of the effective address, and are then sign-extended. Because the program counter is an ordinary register, immediate, absolute and PC-relative operands need no modes of their own. Instruction decode, ALU work and result writeback stay outside the block.

Top module: `opnd_resolver`

## Requirements
- R1: The specifier is split as bits 5:3 = mode and bits 2:0 = register number. In mode 0 the operand is the register's contents. Mode 0 issues no memory read and writes no register. `opnd_is_reg` is 1 and `ea` is 0 in this mode.
- R2: In mode 1 the register contents are the effective address. The register is left unchanged.
- R3: In mode 2 the register contents are the effective address. Afterwards the register grows by 2 for a word operand or by 1 for a byte operand.
- R4: In mode 3 the word at the register's address is the effective address. Afterwards the register grows by 2 regardless of size.
- R5: In mode 4 the register first shrinks by 2 for a word operand or by 1 for a byte operand. The new value is the effective address.
- R6: In mode 5 the register first shrinks by 2. The word at the new address is the effective address.
- R7: In mode 6 the index word is read at the program counter, and the program counter then advances by 2. The effective address is the selected register (read after that advance) plus the index. With register 7 this gives instruction address + 4 + index.
- R8: Mode 7 forms the same sum as mode 6. The word read at that sum is the effective address.
- R9: When register 7 is used with mode 2 or mode 4, the step is 2 even for byte operands. Every write to register 7 keeps its bit 0 unchanged.
- R10: For a word operand `opnd` is the whole word read at `ea`. For a byte operand it is the byte selected by `ea` bit 0 (1 = bits 15:8, 0 = bits 7:0), sign-extended. In mode 0 a byte operand is the register's bits 7:0, sign-extended.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is seen. Each accepted valid completes exactly one read. Modes 0 to 7 use 0, 1, 1, 2, 1, 2, 2 and 3 reads respectively.
- R12: After reset `done`, `mem_req`, `rf_we`, `opnd` and `ea` are all 0. `done` is a single-cycle pulse, and `mem_req` is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving `spec` (taken when idle) |
| spec | input | 6 | Operand specifier: mode in 5:3, register in 2:0 |
| byte_op | input | 1 | 1 = byte operand, 0 = word operand |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory byte address (bit 0 ignored by memory) |
| mem_valid | input | 1 | Read data valid; completes the pending read |
| mem_rdata | input | 16 | Memory read word |
| done | output | 1 | One-cycle completion pulse |
| opnd | output | 16 | Resolved operand value |
| ea | output | 16 | Effective address (0 in mode 0) |
| opnd_is_reg | output | 1 | Operand came from a register (mode 0) |

## Verification
The bench targets byte steps on ordinary registers against the forced step of 2 on the program counter. A design that treated register 7 like the others would leave the program counter odd after a byte auto-increment or auto-decrement. It checks that the deferred modes ignore the size flag; a wrong step there shows up directly in the written-back register. It uses index modes on register 7: a design that read the base before the program counter advance would land 2 bytes short of the relative target. Byte operands at odd addresses expose a swapped half or a zero-extension through a wrong `opnd`. Random read latencies, including zero wait, catch a design that drops its address before valid or counts one response twice.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_INDEX, ST_ADD, ST_PTR, ST_OPER, ST_DONE
  } seq_t;

  typedef enum logic [2:0] {
    AM_REG, AM_DEF, AM_INC, AM_INCDEF, AM_DEC, AM_DECDEF, AM_IDX, AM_IDXDEF
  } amode_t;

  // Auto step: one byte only for byte operands on a non-PC register.
  function automatic logic [WORD_W-1:0] auto_step(input logic is_byte, input logic is_pc);
    return (is_byte && !is_pc) ? WORD_W'(1) : WORD_W'(2);
  endfunction

  // Pick one half of a word and sign-extend it, or pass the whole word.
  function automatic logic [WORD_W-1:0] size_view(input logic [WORD_W-1:0] w,
                                                  input logic hi, input logic is_byte);
    logic [WORD_W/2-1:0] b;
    b = hi ? w[WORD_W-1:WORD_W/2] : w[WORD_W/2-1:0];
    return is_byte ? {{(WORD_W/2){b[WORD_W/2-1]}}, b} : w;
  endfunction
endpackage

// File: rtl/opr_update.sv
// Register update and first address for the cycle in which the register is read.
module opr_update
  import opr_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  amode_t        mode,
  input  logic          is_byte,
  input  logic          is_pc,
  input  logic [DW-1:0] cur,
  output logic          wr,
  output logic [DW-1:0] nxt,
  output logic [DW-1:0] first_addr
);
  logic [DW-1:0] step;
  assign step = DW'(auto_step(is_byte, is_pc));

  always_comb begin
    wr         = 1'b0;
    nxt        = cur;
    first_addr = cur;
    unique case (mode)
      AM_REG, AM_DEF: ;
      AM_INC:    begin wr = 1'b1; nxt = cur + step; end
      AM_INCDEF: begin wr = 1'b1; nxt = cur + DW'(2); end
      AM_DEC:    begin wr = 1'b1; nxt = cur - step; first_addr = nxt; end
      AM_DECDEF: begin wr = 1'b1; nxt = cur - DW'(2); first_addr = nxt; end
      AM_IDX, AM_IDXDEF: begin wr = 1'b1; nxt = cur + DW'(2); end
      default: ;
    endcase
  end
endmodule

// File: rtl/opr_sizesel.sv
// Operand size view: sign-extended byte or whole word.
module opr_sizesel
  import opr_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic [DW-1:0] word_in,
  input  logic          hi_half,
  input  logic          is_byte,
  output logic [DW-1:0] value
);
  assign value = size_view(word_in, hi_half, is_byte);
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opr_pkg::*;
#(
  parameter int DW     = WORD_W,
  parameter int RW     = REG_W,
  parameter int SPEC_W = RW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SPEC_W-1:0] spec,
  input  logic              byte_op,
  output logic [RW-1:0]     rf_raddr,
  input  logic [DW-1:0]     rf_rdata,
  output logic              rf_we,
  output logic [RW-1:0]     rf_waddr,
  output logic [DW-1:0]     rf_wdata,
  output logic              mem_req,
  output logic [DW-1:0]     mem_addr,
  input  logic              mem_valid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              done,
  output logic [DW-1:0]     opnd,
  output logic [DW-1:0]     ea,
  output logic              opnd_is_reg
);
  localparam logic [RW-1:0] PC_IDX = RW'((1 << RW) - 1);

  seq_t          state;
  amode_t        mode_q;
  logic [RW-1:0] reg_q;
  logic          byte_q;
  logic [DW-1:0] addr_q, idx_q, opnd_q, ea_q;
  logic          isreg_q;

  // Named internal events for the checks below.
  logic          load_cycle, idx_mode, rd_accept, read_pc;
  logic [DW-1:0] upd_nxt, upd_addr, sum_addr, mem_view, reg_view;
  logic          upd_wr;

  assign load_cycle = (state == ST_LOAD);
  assign idx_mode   = (mode_q == AM_IDX) || (mode_q == AM_IDXDEF);
  assign read_pc    = load_cycle && idx_mode;
  assign rd_accept  = mem_req && mem_valid;
  assign sum_addr   = rf_rdata + idx_q;

  assign rf_raddr = read_pc ? PC_IDX : reg_q;

  opr_update #(.DW(DW)) u_update (
    .mode       (mode_q),
    .is_byte    (byte_q),
    .is_pc      (rf_raddr == PC_IDX),
    .cur        (rf_rdata),
    .wr         (upd_wr),
    .nxt        (upd_nxt),
    .first_addr (upd_addr)
  );

  opr_sizesel #(.DW(DW)) u_memsel (
    .word_in (mem_rdata),
    .hi_half (addr_q[0]),
    .is_byte (byte_q),
    .value   (mem_view)
  );

  opr_sizesel #(.DW(DW)) u_regsel (
    .word_in (rf_rdata),
    .hi_half (1'b0),
    .is_byte (byte_q),
    .value   (reg_view)
  );

  assign rf_we    = load_cycle && upd_wr;
  assign rf_waddr = rf_raddr;
  assign rf_wdata = upd_nxt;

  assign mem_req  = (state == ST_INDEX) || (state == ST_PTR) || (state == ST_OPER);
  assign mem_addr = addr_q;

  assign done        = (state == ST_DONE);
  assign opnd        = opnd_q;
  assign ea          = ea_q;
  assign opnd_is_reg = isreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mode_q  <= AM_REG;
      reg_q   <= '0;
      byte_q  <= 1'b0;
      addr_q  <= '0;
      idx_q   <= '0;
      opnd_q  <= '0;
      ea_q    <= '0;
      isreg_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          mode_q <= amode_t'(spec[SPEC_W-1:RW]);
          reg_q  <= spec[RW-1:0];
          byte_q <= byte_op;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          addr_q <= upd_addr;
          unique case (mode_q)
            AM_REG: begin
              opnd_q  <= reg_view;
              ea_q    <= '0;
              isreg_q <= 1'b1;
              state   <= ST_DONE;
            end
            AM_DEF, AM_INC, AM_DEC:  state <= ST_OPER;
            AM_INCDEF, AM_DECDEF:    state <= ST_PTR;
            default:                 state <= ST_INDEX;
          endcase
        end
        ST_INDEX: if (mem_valid) begin
          idx_q <= mem_rdata;
          state <= ST_ADD;
        end
        ST_ADD: begin
          addr_q <= sum_addr;
          state  <= (mode_q == AM_IDXDEF) ? ST_PTR : ST_OPER;
        end
        ST_PTR: if (mem_valid) begin
          addr_q <= mem_rdata;
          state  <= ST_OPER;
        end
        ST_OPER: if (mem_valid) begin
          opnd_q  <= mem_view;
          ea_q    <= addr_q;
          isreg_q <= 1'b0;
          state   <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Register writes never come from mode 0 (R1).
  assert_no_write_mode0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mode_q != AM_REG);

  // Program counter keeps its parity on every write-back (R9).
  assert_pc_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_waddr == PC_IDX) |-> rf_wdata[0] == rf_rdata[0]);

  // A pending read holds request and address until valid (R11).
  assert_hold_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // Completion is a single pulse (R12).
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // No read outstanding at completion (R12).
  assert_no_req_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // Results stay put between completion and the next start (R12).
  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $past(done)) |-> ($stable(opnd) && $stable(ea)));
endmodule

// File: tb/test_opnd_resolver.sv
module test_opnd_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  spec = '0;
  logic        byte_op = 1'b0;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_valid = 1'b0;
  logic [15:0] mem_addr, mem_rdata = '0;
  logic        done, opnd_is_reg;
  logic [15:0] opnd, ea;

  logic [15:0] rf [8];
  int          tests = 0, fails = 0, reads = 0, lat = 0;
  bit          hung = 0;

  always #10 clk = ~clk;  // 50 MHz

  opnd_resolver i_opnd_resolver (
    .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .byte_op(byte_op),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .done(done), .opnd(opnd), .ea(ea), .opnd_is_reg(opnd_is_reg)
  );

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;
  always @(posedge clk) if (rst_n && mem_req && mem_valid) reads <= reads + 1;

  // Read-only word memory contents, computed from the word index.
  function automatic logic [15:0] memf(input logic [15:0] a);
    logic [15:0] w;
    w = {1'b0, a[15:1]};
    return (w * 16'h9E37) ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] sx(input logic [7:0] b);
    return {{8{b[7]}}, b};
  endfunction

  // Memory responder with random latency (zero-wait allowed).
  always @(negedge clk) begin
    if (mem_valid) mem_valid = 1'b0;
    else if (mem_req) begin
      if (lat == 0) begin
        mem_valid = 1'b1;
        mem_rdata = memf(mem_addr);
        lat = int'($urandom % 4);
      end else lat = lat - 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Runs one specifier and checks it against a model built from the requirements.
  task automatic run_op(input logic [2:0] m, input logic [2:0] r, input logic b, input string req);
    logic [15:0] e [8];
    logic [15:0] cur, stp, x, eexp, oexp, w;
    int          nrd, r0, wait_n;
    for (int i = 0; i < 8; i++) e[i] = rf[i];
    cur  = rf[r];
    stp  = (b && r != 3'd7) ? 16'd1 : 16'd2;
    eexp = 16'h0;
    nrd  = 0;
    case (m)
      3'd1: begin eexp = cur; nrd = 1; end
      3'd2: begin eexp = cur; e[r] = cur + stp; nrd = 1; end
      3'd3: begin eexp = memf(cur); e[r] = cur + 16'd2; nrd = 2; end
      3'd4: begin e[r] = cur - stp; eexp = e[r]; nrd = 1; end
      3'd5: begin e[r] = cur - 16'd2; eexp = memf(e[r]); nrd = 2; end
      3'd6, 3'd7: begin
        x = memf(rf[7]);
        e[7] = rf[7] + 16'd2;
        eexp = e[r] + x;
        nrd = 2;
        if (m == 3'd7) begin eexp = memf(eexp); nrd = 3; end
      end
      default: ;
    endcase
    if (m == 3'd0) oexp = b ? sx(cur[7:0]) : cur;
    else begin
      w = memf(eexp);
      oexp = b ? sx(eexp[0] ? w[15:8] : w[7:0]) : w;
    end
    r0 = reads;
    @(negedge clk);
    spec = {m, r}; byte_op = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 100) begin @(negedge clk); wait_n++; end
    if (!done) begin
      hung = 1; tests++; fails++;
      $display("FAIL R12 watchdog: actual no done expected done (mode %0d)", m);
      return;
    end
    chk(req, "opnd", opnd, oexp);
    chk("R10", "opnd size view", opnd, oexp);
    chk(req, "ea", ea, eexp);
    chk("R1", "opnd_is_reg", {15'b0, opnd_is_reg}, {15'b0, m == 3'd0});
    chk("R12", "mem_req at done", {15'b0, mem_req}, 16'h0);
    for (int i = 0; i < 8; i++) chk(req, $sformatf("reg %0d", i), rf[i], e[i]);
    chk("R11", "read count", 16'(reads - r0), 16'(nrd));
    @(negedge clk);
    chk("R12", "done pulse", {15'b0, done}, 16'h0);
  endtask

  task automatic seed_regs();
    for (int i = 0; i < 8; i++) rf[i] = 16'($urandom);
    rf[7][0] = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2011));
    seed_regs();
    repeat (3) @(negedge clk);
    chk("R12", "reset done", {15'b0, done}, 16'h0);
    chk("R12", "reset mem_req", {15'b0, mem_req}, 16'h0);
    chk("R12", "reset rf_we", {15'b0, rf_we}, 16'h0);
    chk("R12", "reset opnd", opnd, 16'h0);
    chk("R12", "reset ea", ea, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases.
    rf[2] = 16'h0081; run_op(3'd0, 3'd2, 1'b1, "R1");   // byte sign-extension from register
    run_op(3'd0, 3'd2, 1'b0, "R1");
    run_op(3'd1, 3'd4, 1'b0, "R2");
    rf[3] = 16'h1001; run_op(3'd1, 3'd3, 1'b1, "R10");  // odd address, high byte
    run_op(3'd2, 3'd3, 1'b1, "R3");                      // byte step 1
    run_op(3'd2, 3'd3, 1'b0, "R3");
    run_op(3'd3, 3'd5, 1'b1, "R4");                      // size ignored
    run_op(3'd4, 3'd1, 1'b1, "R5");
    run_op(3'd4, 3'd1, 1'b0, "R5");
    run_op(3'd5, 3'd6, 1'b1, "R6");
    run_op(3'd2, 3'd7, 1'b1, "R9");                      // immediate byte: step 2
    run_op(3'd4, 3'd7, 1'b1, "R9");
    run_op(3'd3, 3'd7, 1'b0, "R4");                      // absolute
    rf[7] = 16'h0202; run_op(3'd6, 3'd7, 1'b0, "R7");    // relative
    run_op(3'd6, 3'd0, 1'b0, "R7");
    run_op(3'd7, 3'd7, 1'b0, "R8");
    run_op(3'd7, 3'd4, 1'b1, "R8");
    chk("R9", "pc even", {15'b0, rf[7][0]}, 16'h0);

    // Constrained random mix.
    for (int k = 0; k < 120 && !hung; k++) begin
      logic [2:0] m, r;
      if (k % 16 == 0) seed_regs();
      m = 3'($urandom); r = 3'($urandom);
      run_op(m, r, 1'($urandom), $sformatf("R%0d", (m == 3'd0) ? 1 : m + 1));
    end
    chk("R9", "pc even after random", {15'b0, rf[7][0]}, 16'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule